// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block is the address datapath of a microprogrammed controller. Each cycle it picks the next control-store address from one of four sources: the incremented microprogram counter, a shared holding register that also serves as the loop counter, the top of a small return-address stack, or a direct address bus. The selected address leaves the block at once, without a register on the path. On every clock edge, the microprogram counter takes that address plus one.

An external instruction decoder drives the block. It supplies an already-decoded two-bit source select, an active-low stack strobe with a push/pop direction, an active-low counter load and an active-low counter decrement, and an active-low map request. The block returns a counter-zero flag for conditional tests. It also passes the map request on as a strobe, which tells an external mapping source to drive the direct bus.

A subroutine call pushes the current counter and selects the direct bus. A return selects the stack top and pops. A repeat loop loads the counter, decrements it and tests the zero flag.

Top module: `useq_next_addr`

## Requirements
- R1: `next_addr` is combinational from `src_sel`: 2'b00 gives the microprogram counter, 2'b01 the holding register, 2'b10 the stack top, and 2'b11 `dbus`.
- R2: On every clock edge that is not a reset, the microprogram counter loads `next_addr + 1`, modulo 2^AW, so 0xFFF wraps to 0x000.
- R3: A synchronous active-high `rst` clears the microprogram counter, the stack depth and the holding register. After reset, `cnt_zero` is 1 and every source except `dbus` reads 0.
- R4: When `stk_en_n` is low, `stk_dir` 1 pushes the current microprogram counter value and `stk_dir` 0 pops. When `stk_en_n` is high, the stack does not change.
- R5: The stack holds DEPTH (4) entries. A push while full overwrites the top entry and leaves the entries below it intact.
- R6: A pop while empty leaves the stack empty. The stack top reads 0 while the stack is empty.
- R7: When `cnt_ld_n` is low, the holding register loads `dbus`. A load takes priority over a decrement in the same cycle.
- R8: When `cnt_dec_n` is low and `cnt_ld_n` is high, the holding register decrements by one. At zero it stays at zero.
- R9: `cnt_zero` is 1 exactly when the holding register is zero.
- R10: `map_oe_n` follows `map_req_n` in the same cycle.
- R11: A push and a counter load in the same cycle both take effect. The stack receives the microprogram counter and the holding register receives `dbus`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 2 | Next-address source select |
| stk_en_n | input | 1 | Stack operation strobe, active low |
| stk_dir | input | 1 | Stack direction: 1 push, 0 pop |
| cnt_ld_n | input | 1 | Holding register load from `dbus`, active low |
| cnt_dec_n | input | 1 | Holding register decrement, active low |
| map_req_n | input | 1 | Map request from the decoder, active low |
| dbus | input | AW | Direct address / load data bus |
| next_addr | output | AW | Selected next microprogram address |
| cnt_zero | output | 1 | Holding register equals zero |
| map_oe_n | output | 1 | Enable for the external mapping source, active low |

## Verification
A wrong microprogram counter appears on `next_addr` one cycle later, whenever select 00 is used. A wrong stack pointer or stack entry stays hidden until the stack is selected. It then shows as a wrong return address, often several pushes or pops after the fault. For that reason, the push and pop scenarios read the top after every operation, including at full and at empty. A holding register that is off by one shows on `cnt_zero` only when the count crosses zero. The counter is therefore also read directly through select 01 at each step.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    SRC_PC    = 2'b00,
    SRC_HOLD  = 2'b01,
    SRC_STACK = 2'b10,
    SRC_DBUS  = 2'b11
  } src_e;
endpackage

// File: rtl/useq_pc.sv
module useq_pc #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] pc_q
);
  function automatic logic [AW-1:0] addr_inc(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= addr_inc(addr_in);
  end
endmodule

// File: rtl/useq_hold.sv
module useq_hold #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_n,
  input  logic          dec_n,
  input  logic [AW-1:0] ld_val,
  output logic [AW-1:0] hold_q,
  output logic          is_zero
);
  function automatic logic [AW-1:0] cnt_next(input logic [AW-1:0] cur,
                                             input logic ld, input logic dec,
                                             input logic [AW-1:0] val);
    if (ld)                  return val;
    else if (dec && cur != '0) return cur - AW'(1);
    else                     return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else     hold_q <= cnt_next(hold_q, !ld_n, !dec_n, ld_val);
  end

  assign is_zero = (hold_q == '0);
endmodule

// File: rtl/useq_stack.sv
module useq_stack #(
  parameter int AW    = 12,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic                         pop,
  input  logic [AW-1:0]                wr_data,
  output logic [AW-1:0]                top,
  output logic [$clog2(DEPTH+1)-1:0]   depth
);
  localparam int PW = $clog2(DEPTH+1);

  logic [AW-1:0] mem [DEPTH];
  logic          full, empty;
  logic [PW-1:0] wr_idx;

  assign full   = (depth == PW'(DEPTH));
  assign empty  = (depth == '0);
  assign wr_idx = full ? PW'(DEPTH-1) : depth;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst && push && wr_idx == PW'(g)) mem[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                depth <= '0;
    else if (push && !full) depth <= depth + PW'(1);
    else if (pop && !empty) depth <= depth - PW'(1);
  end

  always_comb begin
    top = '0;
    for (int k = 0; k < DEPTH; k++)
      if (depth == PW'(k+1)) top = mem[k];
  end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr #(
  parameter int AW    = 12,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    src_sel,
  input  logic          stk_en_n,
  input  logic          stk_dir,
  input  logic          cnt_ld_n,
  input  logic          cnt_dec_n,
  input  logic          map_req_n,
  input  logic [AW-1:0] dbus,
  output logic [AW-1:0] next_addr,
  output logic          cnt_zero,
  output logic          map_oe_n
);
  import useq_pkg::*;
  localparam int PW = $clog2(DEPTH+1);

  logic [AW-1:0] pc_q;
  logic [AW-1:0] hold_q;
  logic [AW-1:0] stk_top;
  logic [PW-1:0] stk_depth;
  logic          push_ev;
  logic          pop_ev;
  src_e          src;

  assign push_ev = !stk_en_n &&  stk_dir;
  assign pop_ev  = !stk_en_n && !stk_dir;
  assign src     = src_e'(src_sel);

  always_comb begin
    unique case (src)
      SRC_PC:    next_addr = pc_q;
      SRC_HOLD:  next_addr = hold_q;
      SRC_STACK: next_addr = stk_top;
      default:   next_addr = dbus;
    endcase
  end

  useq_pc #(.AW(AW)) u_pc (
    .clk(clk), .rst(rst), .addr_in(next_addr), .pc_q(pc_q)
  );

  useq_hold #(.AW(AW)) u_hold (
    .clk(clk), .rst(rst), .ld_n(cnt_ld_n), .dec_n(cnt_dec_n),
    .ld_val(dbus), .hold_q(hold_q), .is_zero(cnt_zero)
  );

  useq_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst(rst), .push(push_ev), .pop(pop_ev),
    .wr_data(pc_q), .top(stk_top), .depth(stk_depth)
  );

  assign map_oe_n = map_req_n;
endmodule

// File: rtl/useq_next_addr_chk.sv
module useq_next_addr_chk #(
  parameter int AW    = 12,
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       stk_en_n,
  input logic                       cnt_ld_n,
  input logic [AW-1:0]              dbus,
  input logic [AW-1:0]              next_addr,
  input logic                       cnt_zero,
  input logic [AW-1:0]              pc_q,
  input logic [AW-1:0]              stk_top,
  input logic [$clog2(DEPTH+1)-1:0] stk_depth,
  input logic                       push_ev,
  input logic                       pop_ev
);
  localparam int PW = $clog2(DEPTH+1);

  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= !rst;

  p_pc_seq_r2: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> pc_q == $past(next_addr) + AW'(1));

  p_reset_r3: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && stk_depth == '0 && cnt_zero));

  p_push_val_r4: assert property (@(posedge clk) disable iff (rst)
    push_ev |=> stk_top == $past(pc_q));

  p_idle_stack_r4: assert property (@(posedge clk) disable iff (rst)
    stk_en_n |=> $stable(stk_depth));

  p_full_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (push_ev && stk_depth == PW'(DEPTH)) |=> stk_depth == PW'(DEPTH));

  p_empty_pop_r6: assert property (@(posedge clk) disable iff (rst)
    (pop_ev && stk_depth == '0) |=> (stk_depth == '0 && stk_top == '0));

  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    !cnt_ld_n |=> cnt_zero == ($past(dbus) == '0));

  p_floor_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt_zero && cnt_ld_n) |=> cnt_zero);
endmodule

bind useq_next_addr useq_next_addr_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .stk_en_n(stk_en_n), .cnt_ld_n(cnt_ld_n),
  .dbus(dbus), .next_addr(next_addr), .cnt_zero(cnt_zero), .pc_q(pc_q),
  .stk_top(stk_top), .stk_depth(stk_depth), .push_ev(push_ev), .pop_ev(pop_ev)
);

// File: tb/useq_next_addr_tb.sv
module useq_next_addr_tb;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    src_sel = 2'b00;
  logic          stk_en_n = 1'b1, stk_dir = 1'b0;
  logic          cnt_ld_n = 1'b1, cnt_dec_n = 1'b1, map_req_n = 1'b1;
  logic [AW-1:0] dbus = '0;
  logic [AW-1:0] next_addr;
  logic          cnt_zero, map_oe_n;
  int            n_chk = 0, n_bad = 0;
  bit            done = 0;

  always #5 clk = ~clk;

  useq_next_addr #(.AW(AW), .DEPTH(4)) u_dut (
    .clk(clk), .rst(rst), .src_sel(src_sel), .stk_en_n(stk_en_n),
    .stk_dir(stk_dir), .cnt_ld_n(cnt_ld_n), .cnt_dec_n(cnt_dec_n),
    .map_req_n(map_req_n), .dbus(dbus), .next_addr(next_addr),
    .cnt_zero(cnt_zero), .map_oe_n(map_oe_n)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic drive(logic [1:0] s, logic en_n, logic dir, logic ld_n,
                       logic dec_n, logic [AW-1:0] d);
    src_sel = s; stk_en_n = en_n; stk_dir = dir;
    cnt_ld_n = ld_n; cnt_dec_n = dec_n; dbus = d;
  endtask

  task automatic look(logic [1:0] s, string req, logic [AW-1:0] exp);
    drive(s, 1'b1, 1'b0, 1'b1, 1'b1, dbus);
    #1 chk(req, 16'(next_addr), 16'(exp));
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
    look(2'b00, "R3 pc after reset", 12'h000);
    look(2'b01, "R3 hold after reset", 12'h000);
    chk("R3 cnt_zero after reset", 16'(cnt_zero), 16'd1);
    look(2'b10, "R6 empty top after reset", 12'h000);
  endtask

  task automatic t_pc();
    drive(2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 12'h100);
    #1 chk("R1 dbus source", 16'(next_addr), 16'h100);
    tick();
    look(2'b00, "R2 pc = addr+1", 12'h101);
    tick();
    look(2'b00, "R2 pc sequential", 12'h102);
    drive(2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 12'hFFF); tick();
    look(2'b00, "R2 pc wrap", 12'h000);
  endtask

  task automatic t_count();
    drive(2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 12'h005); tick();
    look(2'b01, "R7 load hold", 12'h005);
    chk("R9 nonzero flag", 16'(cnt_zero), 16'd0);
    for (int k = 4; k >= 0; k--) begin
      drive(2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 12'h000); tick();
      look(2'b01, "R8 decrement", 12'(k));
      chk("R9 zero flag", 16'(cnt_zero), 16'(k == 0));
    end
    drive(2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 12'h000); tick();
    look(2'b01, "R8 hold at zero", 12'h000);
    drive(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 12'h003); tick();
    look(2'b01, "R7 load beats decrement", 12'h003);
    drive(2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 12'h000); tick();
    look(2'b01, "R7 no strobe keeps value", 12'h003);
  endtask

  task automatic t_stack();
    logic [AW-1:0] exp_top [5];
    exp_top = '{12'h201, 12'h301, 12'h311, 12'h321, 12'h331};
    drive(2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 12'h200); tick();
    for (int n = 0; n < 4; n++) begin
      drive(2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 12'(12'h300 + n*16)); tick();
      look(2'b10, "R4 push current pc", exp_top[n]);
    end
    drive(2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 12'h400); tick();
    look(2'b10, "R5 push at full overwrites top", exp_top[4]);
    drive(2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 12'h000); tick();
    look(2'b10, "R4 no strobe no change", exp_top[4]);
    drive(2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 12'h000); tick();
    look(2'b10, "R5 entry below kept", 12'h311);
    drive(2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 12'h000); tick();
    look(2'b10, "R4 pop", 12'h301);
    drive(2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 12'h000); tick();
    look(2'b10, "R4 pop", 12'h201);
    drive(2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 12'h000); tick();
    look(2'b10, "R6 empty top", 12'h000);
    drive(2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 12'h0A0); tick();
    look(2'b10, "R6 pop at empty", 12'h000);
    drive(2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 12'h500); tick();
    look(2'b10, "R6 push after empty pop", 12'h0A1);
    drive(2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 12'h000); tick();
    look(2'b10, "R6 depth did not underflow", 12'h000);
  endtask

  task automatic t_call_load();
    drive(2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 12'h610); tick();
    drive(2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 12'h055);
    #1 chk("R11 call selects dbus", 16'(next_addr), 16'h055);
    tick();
    look(2'b10, "R11 pushed pc", 12'h611);
    look(2'b01, "R11 loaded hold", 12'h055);
    look(2'b00, "R11 pc after call", 12'h056);
  endtask

  task automatic t_map();
    map_req_n = 1'b0;
    #1 chk("R10 map strobe low", 16'(map_oe_n), 16'd0);
    map_req_n = 1'b1;
    #1 chk("R10 map strobe high", 16'(map_oe_n), 16'd1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_pc();
    t_count();
    t_stack();
    t_call_load();
    t_map();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule